// File: doc/BRIEF.md
# Saturating-Counter Branch Prediction Buffer

This block holds a table of small saturating counters, one for each slot, and the slot for a branch is picked by the low bits of its instruction address. The fetch stage presents an address and gets a taken or not-taken guess back in the same cycle. When the branch resolves later in the pipeline, the execute stage sends the branch address and its real direction back. The chosen counter then steps one place toward "taken" or toward "not taken" and stops at either end, so a single odd outcome does not flip a branch that has a strong history.

The counter width is generic. The guess is "taken" once a counter reaches half of its full-scale value, rounded up. Reset, or a request from the pipeline, starts a sweep that writes every slot back to the strongly-not-taken value, one slot per cycle. Two free-running statistics counters can be built in. One counts lookups and the other counts resolved branches whose fetch-time guess was wrong.

Top module: `branch_pred_buffer`

## Requirements
- R1: The slot is chosen by address bits [IDX_W+1:2], where IDX_W = log2(DEPTH). Address bits [1:0] and all bits above IDX_W+1 have no effect on which slot is read or written.
- R2: `lk_taken` is 1 exactly when the addressed counter is at least 2^(CTR_W-1), and no sweep is running. With CTR_W = 2, counter values 0 and 1 give 0, and values 2 and 3 give 1.
- R3: An accepted update with `up_taken` = 1 raises the selected counter by one. At 2^CTR_W − 1 the counter stays where it is.
- R4: An accepted update with `up_taken` = 0 lowers the selected counter by one. At 0 the counter stays where it is.
- R5: After a reset sweep or a requested sweep, every slot holds 0 (strongly not taken), so every address predicts not taken.
- R6: Four taken updates to a slot that starts at 0 pass it through 1, 2, 3 and 3. The predictions read after each update are not taken, taken, taken, taken.
- R7: An update takes effect at the clock edge. A lookup of the same slot in the same cycle as the update still returns the prediction from before the update.
- R8: Reset, or `init_req` while idle, starts a sweep. `busy` then stays high for exactly DEPTH cycles. While `busy` is high, updates are ignored, `init_req` is ignored and `lk_taken` is 0.
- R9: `look_cnt` counts the cycles in which `lk_valid` is 1 and `busy` is 0. It wraps at 2^STAT_W.
- R10: `miss_cnt` counts the accepted updates whose `up_pred` differs from `up_taken`. Updates that are ignored during a sweep do not count.
- R11: Both statistics counters read 0 during reset and after it. A requested sweep leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a clearing sweep |
| init_req | input | 1 | Request a clearing sweep of all slots |
| busy | output | 1 | A clearing sweep is running |
| lk_valid | input | 1 | A lookup is being made this cycle (for statistics only) |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Prediction for `lk_pc` (combinational) |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |
| up_pred | input | 1 | Prediction that was made at fetch for this branch |
| look_cnt | output | STAT_W | Number of lookups counted |
| miss_cnt | output | STAT_W | Number of mispredictions counted |

## Verification
A small 16-slot, 2-bit configuration is used. The bench sweeps every slot after both kinds of clearing and walks one slot through the always-taken loop trace. These two show whether the reset value is right and whether the threshold is placed correctly. Runs of not-taken updates against a saturated counter, and of taken updates against a cleared counter, tell the clamping at each end apart from wrap-around. A single reversal from the strong state shows the hysteresis. Address pairs that differ only in the byte offset or in the high bits test the index selection. A same-cycle update and lookup on one slot shows when a write becomes visible. A long pseudo-random run of updates is compared against an arithmetic model of every counter, and the miss tally is compared as well.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_state_e;

    typedef struct packed {
        logic valid;
        logic taken;
        logic guessed;
    } bp_outcome_t;

    // Step a counter one place toward the top or bottom, clamping at both ends.
    function automatic logic [7:0] sat_step(logic [7:0] cur, logic [7:0] top, logic up);
        if (up) begin
            return (cur == top) ? cur : cur + 8'd1;
        end
        return (cur == 8'd0) ? cur : cur - 8'd1;
    endfunction

    // Slot number taken from the word address bits.
    function automatic logic [15:0] slot_of(logic [63:0] addr, int idx_bits);
        logic [63:0] shifted;
        shifted = addr >> 2;
        return 16'(shifted & ((64'd1 << idx_bits) - 64'd1));
    endfunction

endpackage

// File: rtl/bp_sweep_ctrl.sv
module bp_sweep_ctrl #(
    parameter int DEPTH = 4096,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    import bp_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    sweep_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SWEEP_RUN;
            idx   <= '0;
        end else begin
            case (state)
                SWEEP_IDLE: begin
                    if (start) begin
                        state <= SWEEP_RUN;
                        idx   <= '0;
                    end
                end
                SWEEP_RUN: begin
                    if (idx == LAST) begin
                        state <= SWEEP_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= SWEEP_IDLE;
            endcase
        end
    end

    assign busy = (state == SWEEP_RUN);

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
    parameter int DEPTH = 4096,
    parameter int CTR_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr
);
    import bp_pkg::*;

    localparam logic [CTR_W-1:0] TOP = '1;

    logic [CTR_W-1:0] table_q [DEPTH];
    logic [CTR_W-1:0] upd_cur;
    logic [CTR_W-1:0] upd_nxt;

    assign upd_cur = table_q[upd_idx];
    assign upd_nxt = CTR_W'(sat_step(8'(upd_cur), 8'(TOP), upd_up));
    assign rd_ctr  = table_q[rd_idx];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            table_q[clr_idx] <= '0;
        end else if (upd_en) begin
            table_q[upd_idx] <= upd_nxt;
        end
    end

endmodule

// File: rtl/bp_stats.sv
module bp_stats #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              look_hit,
    input  logic              miss_hit,
    output logic [STAT_W-1:0] look_cnt,
    output logic [STAT_W-1:0] miss_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            look_cnt <= '0;
            miss_cnt <= '0;
        end else begin
            if (look_hit) look_cnt <= look_cnt + 1'b1;
            if (miss_hit) miss_cnt <= miss_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/branch_pred_buffer.sv
module branch_pred_buffer #(
    parameter int DEPTH    = 4096,
    parameter int CTR_W    = 2,
    parameter int PC_W     = 32,
    parameter int STAT_W   = 32,
    parameter bit STATS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_req,
    output logic              busy,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic              up_pred,
    output logic [STAT_W-1:0] look_cnt,
    output logic [STAT_W-1:0] miss_cnt
);
    import bp_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CTR_W-1:0] THRESH = CTR_W'(1) << (CTR_W - 1);

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [IDX_W-1:0] sweep_idx;
    logic [CTR_W-1:0] lk_ctr;
    bp_outcome_t      outcome;
    logic             accept_upd;
    logic             unused_pc_bits;

    assign lk_idx = lk_pc[IDX_W+1:2];
    assign up_idx = up_pc[IDX_W+1:2];
    assign unused_pc_bits = ^{lk_pc[1:0], lk_pc[PC_W-1:IDX_W+2],
                              up_pc[1:0], up_pc[PC_W-1:IDX_W+2]};

    assign outcome.valid   = up_valid;
    assign outcome.taken   = up_taken;
    assign outcome.guessed = up_pred;
    assign accept_upd      = outcome.valid && !busy;

    bp_sweep_ctrl #(.DEPTH(DEPTH)) u_sweep (
        .clk   (clk),
        .rst   (rst),
        .start (init_req),
        .busy  (busy),
        .idx   (sweep_idx)
    );

    bp_counter_table #(.DEPTH(DEPTH), .CTR_W(CTR_W)) u_table (
        .clk     (clk),
        .clr_en  (busy),
        .clr_idx (sweep_idx),
        .upd_en  (accept_upd),
        .upd_idx (up_idx),
        .upd_up  (outcome.taken),
        .rd_idx  (lk_idx),
        .rd_ctr  (lk_ctr)
    );

    assign lk_taken = !busy && (lk_ctr >= THRESH);

    generate
        if (STATS_EN) begin : g_stats
            bp_stats #(.STAT_W(STAT_W)) u_stats (
                .clk      (clk),
                .rst      (rst),
                .look_hit (lk_valid && !busy),
                .miss_hit (accept_upd && (outcome.guessed != outcome.taken)),
                .look_cnt (look_cnt),
                .miss_cnt (miss_cnt)
            );
        end else begin : g_no_stats
            logic unused_stat_in;
            assign unused_stat_in = lk_valid ^ outcome.guessed;
            assign look_cnt = '0;
            assign miss_cnt = '0;
        end
    endgenerate

endmodule

// File: rtl/bp_buffer_chk.sv
module bp_buffer_chk #(
    parameter int DEPTH  = 4096,
    parameter int PC_W   = 32,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              lk_valid,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic              up_valid,
    input logic [PC_W-1:0]   up_pc,
    input logic              up_taken,
    input logic              up_pred,
    input logic [STAT_W-1:0] look_cnt,
    input logic [STAT_W-1:0] miss_cnt
);
    localparam int IDX_W = $clog2(DEPTH);

    int run_len;
    logic same_slot;
    assign same_slot = (lk_pc[IDX_W+1:2] == up_pc[IDX_W+1:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= 0;
        end else begin
            assert_busy_len_R8: assert (run_len <= DEPTH)
                else $error("sweep longer than depth");
            run_len <= busy ? run_len + 1 : 0;
        end
    end

    assert_quiet_sweep_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !lk_taken);

    assert_top_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && !busy && same_slot && lk_taken)
        |=> (!$stable(lk_pc) || busy || lk_taken));

    assert_bottom_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_taken && !busy && same_slot && !lk_taken)
        |=> (!$stable(lk_pc) || lk_taken == 1'b0));

    assert_miss_cause_R10: assert property (@(posedge clk) disable iff (rst)
        (miss_cnt != $past(miss_cnt))
        |-> ($past(up_valid && !busy && (up_pred != up_taken))
             && miss_cnt == $past(miss_cnt) + 1'b1));

    assert_look_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (look_cnt != $past(look_cnt))
        |-> ($past(lk_valid && !busy) && look_cnt == $past(look_cnt) + 1'b1));

endmodule

bind branch_pred_buffer bp_buffer_chk #(
    .DEPTH(DEPTH), .PC_W(PC_W), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_taken(lk_taken), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_pred(up_pred), .look_cnt(look_cnt), .miss_cnt(miss_cnt)
);

// File: tb/branch_pred_buffer_tb.sv
module branch_pred_buffer_tb;
    localparam int DEPTH = 16;
    localparam int CTR_W = 2;
    localparam int PC_W = 16;
    localparam int STAT_W = 16;
    localparam int TOPV = 3;
    localparam int THR = 2;

    logic clk = 1'b0;
    logic rst, init_req, busy, lk_valid, lk_taken, up_valid, up_taken, up_pred;
    logic [PC_W-1:0] lk_pc, up_pc;
    logic [STAT_W-1:0] look_cnt, miss_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int mdl [DEPTH];
    int exp_look = 0;
    int exp_miss = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    branch_pred_buffer #(
        .DEPTH(DEPTH), .CTR_W(CTR_W), .PC_W(PC_W), .STAT_W(STAT_W), .STATS_EN(1'b1)
    ) u_dut (
        .clk(clk), .rst(rst), .init_req(init_req), .busy(busy),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_pred(up_pred),
        .look_cnt(look_cnt), .miss_cnt(miss_cnt)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic logic [PC_W-1:0] mkpc(input int slot, input int hi, input int lo);
        return PC_W'((hi << 6) | (slot << 2) | (lo & 3));
    endfunction

    // Drive at a falling edge, let it pass a rising edge, return at the next falling edge.
    task automatic upd(input logic [PC_W-1:0] pc, input logic t, input logic p);
        int s;
        s = int'(pc[5:2]);
        up_pc = pc; up_taken = t; up_pred = p; up_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        if (t) mdl[s] = (mdl[s] == TOPV) ? TOPV : mdl[s] + 1;
        else   mdl[s] = (mdl[s] == 0) ? 0 : mdl[s] - 1;
        if (t != p) exp_miss++;
    endtask

    task automatic look(input string req, input logic [PC_W-1:0] pc);
        lk_pc = pc;
        #1;
        chk(req, int'(lk_taken), (mdl[int'(pc[5:2])] >= THR) ? 1 : 0);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        rst = 1'b1; init_req = 1'b0; lk_valid = 1'b0; lk_pc = '0;
        up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; up_pred = 1'b0;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
        repeat (3) @(negedge clk);
        chk("R11 look_cnt in reset", int'(look_cnt), 0);
        chk("R11 miss_cnt in reset", int'(miss_cnt), 0);
        chk("R8 busy in reset", int'(busy), 1);
        rst = 1'b0;
        count_busy(n);
        chk("R8 reset sweep length", n, DEPTH);

        // R5: every slot cleared after the reset sweep
        for (int i = 0; i < DEPTH; i++) look("R5 slot after reset", mkpc(i, i, i));

        // R6: loop trace from strongly not taken
        for (int k = 0; k < 4; k++) begin
            upd(mkpc(3, 0, 0), 1'b1, (mdl[3] >= THR));
            look("R6 loop trace", mkpc(3, 0, 0));
        end
        chk("R6 trace final pred", int'(lk_taken), 1);

        // R3: extra taken at top; R4 single reversal keeps taken, second flips
        upd(mkpc(3, 1, 2), 1'b1, 1'b1);
        look("R3 saturate high", mkpc(3, 2, 1));
        upd(mkpc(3, 0, 0), 1'b0, 1'b1);
        look("R2 hysteresis one reversal", mkpc(3, 0, 0));
        chk("R2 still taken at 2", int'(lk_taken), 1);
        upd(mkpc(3, 0, 0), 1'b0, 1'b1);
        look("R2 flip at 1", mkpc(3, 0, 0));
        chk("R2 not taken at 1", int'(lk_taken), 0);
        for (int k = 0; k < 3; k++) upd(mkpc(3, 0, 0), 1'b0, 1'b0);
        upd(mkpc(3, 0, 0), 1'b1, 1'b0);
        look("R4 saturate low", mkpc(3, 0, 0));
        chk("R4 low clamp not taken", int'(lk_taken), 0);
        upd(mkpc(3, 0, 0), 1'b1, 1'b0);
        look("R4 low clamp then rise", mkpc(3, 0, 0));
        chk("R4 two taken from 0", int'(lk_taken), 1);

        // R1: offset and high bits do not pick the slot
        upd(mkpc(12, 255, 3), 1'b1, 1'b0);
        upd(mkpc(12, 7, 1), 1'b1, 1'b0);
        look("R1 alias via high/offset", mkpc(12, 0, 2));
        chk("R1 alias taken", int'(lk_taken), 1);
        look("R1 neighbour untouched", mkpc(13, 0, 0));
        look("R1 neighbour below", mkpc(11, 255, 3));

        // R7: same-cycle update does not change current lookup
        upd(mkpc(9, 0, 0), 1'b1, 1'b0);
        lk_pc = mkpc(9, 0, 0);
        up_pc = mkpc(9, 3, 0); up_taken = 1'b1; up_pred = 1'b0; up_valid = 1'b1;
        #1;
        chk("R7 old value same cycle", int'(lk_taken), 0);
        @(posedge clk);
        #1;
        chk("R7 new value after edge", int'(lk_taken), 1);
        @(negedge clk);
        up_valid = 1'b0;
        mdl[9] = 2; exp_miss++;

        // Pseudo-random sweep against the model
        for (int it = 0; it < 600; it++) begin
            logic [PC_W-1:0] pc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc = PC_W'(lfsr);
            upd(pc, lfsr[7] ^ lfsr[0], lfsr[3]);
            look("R3 R4 random model", pc);
        end
        chk("R10 miss tally", int'(miss_cnt), exp_miss);

        // R9: lookup counting
        lk_valid = 1'b1;
        repeat (7) @(negedge clk);
        lk_valid = 1'b0;
        exp_look += 7;
        chk("R9 lookup tally", int'(look_cnt), exp_look);

        // R8: requested sweep, ignored inputs while busy
        upd(mkpc(5, 0, 0), 1'b1, 1'b1);
        upd(mkpc(5, 0, 0), 1'b1, 1'b1);
        look("R2 trained before sweep", mkpc(5, 0, 0));
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        chk("R8 busy after request", int'(busy), 1);
        lk_pc = mkpc(5, 0, 0);
        #1;
        chk("R8 no taken while busy", int'(lk_taken), 0);
        n = 0;
        lk_valid = 1'b1;
        while (busy && n < 100) begin
            n++;
            up_valid = (n == 1 || n == 2);
            up_pc = mkpc(6, 0, 0); up_taken = 1'b1; up_pred = 1'b0;
            init_req = (n >= 2 && n <= 5);
            @(negedge clk);
        end
        lk_valid = 1'b0; up_valid = 1'b0; init_req = 1'b0;
        chk("R8 request sweep length", n, DEPTH);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
        for (int i = 0; i < DEPTH; i++) look("R5 slot after request", mkpc(i, 1, 0));
        lk_pc = mkpc(6, 0, 0);
        #1;
        chk("R8 busy update dropped", int'(lk_taken), 0);
        chk("R10 busy miss not counted", int'(miss_cnt), exp_miss);
        chk("R9 busy lookups not counted", int'(look_cnt), exp_look);
        chk("R11 stats kept over sweep", int'(look_cnt != 0), 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule